// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block sequences the external memory bus of a small 8-bit controller core with a 16-bit address space. The low address byte and the data byte share one bidirectional 8-bit bus. The upper address byte has pins of its own. The core side hands over one request at a time: a cycle kind, an address and, for writes, a data byte. When the cycle completes, the block returns a one-clock completion pulse and, for read-type cycles, the captured byte.

Each bus cycle is divided into states of three oscillator clocks each. An opcode fetch spans four states. The last state is left for internal work. Reads, writes and internal (non-memory) cycles span three states.

Within the cycle, the phase inside each state decides when the following happen:
- the address strobe is raised;
- the shared bus turns from address to data or is released;
- the active-low read and write strobes move.

An external transparent latch captures the low address while the strobe is high.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset and whenever no cycle is running, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `req_ready` is 1, and `addr_hi` keeps the upper byte of the last accepted address.
- R2: A state is exactly 3 clocks. `req_kind` is encoded as 00 fetch, 01 read, 10 write and 11 internal. A fetch keeps `req_ready` low for 12 clocks. The other kinds keep it low for 9 clocks, counted from the clock after the edge that accepts `req_valid`.
- R3: `addr_hi` equals bits 15:8 of the request address for every clock of the cycle.
- R4: For fetch, read and write, `ale` is high only in the first clock of T1. `ad_out` carries address bits 7:0 with `ad_oe` high during the first two clocks of T1, so `ale` falls one clock before the bus changes.
- R5: For fetch and read, `ad_oe` is low from the third clock of T1 onward, and `rd_n` is low from the first clock of T1 through the last clock of T3.
- R6: For fetch and read, the byte on `ad_in` in the last clock of T3 appears on `rdata` when `done` is high.
- R7: For write, `ad_oe` stays high through the last clock of T3, and `ad_out` carries the write byte from the third clock of T1.
- R8: For write, `wr_n` is low from the second (middle) clock of T1 through the end of T2, and it rises at the start of T3.
- R9: An internal cycle (kind 11) raises neither `ale` nor `ad_oe`, and `rd_n` and `wr_n` stay high.
- R10: `done` is high for exactly one clock, in the first idle clock after a cycle. A request presented in that same clock starts the next cycle with no gap. `req_valid` is ignored while a cycle runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write, 11 internal |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Sequencer idle, a request is taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured in a fetch or read |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared bus outgoing value |
| ad_oe | output | 1 | Shared bus driver enable |
| ad_in | input | 8 | Shared bus incoming value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bench builds the block with its defaults: 3 clocks per state, 4 fetch states, 3 transfer states, a 16-bit address and an 8-bit data bus. With three clocks per state, the middle phase of T1 is a distinct clock from both the address-strobe clock and the data-turn clock. This lets the bench check separately that the write strobe starts mid-state, that the strobe falls before the bus changes, and that the strobe rises at the state boundary.

A memory behind a transparent address latch returns data and takes writes. Written bytes are therefore read back through the full latch path, including addresses 0x00FF and 0xFFFF.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_INTRN = 2'b11
  } cyc_e;

  // number of states occupied by a cycle of the given kind
  function automatic int unsigned cyc_states(cyc_e kind, int unsigned fetch_n,
                                             int unsigned xfer_n);
    return (kind == CYC_FETCH) ? fetch_n : xfer_n;
  endfunction

  function automatic logic uses_bus(cyc_e kind);
    return kind != CYC_INTRN;
  endfunction

  function automatic logic reads_bus(cyc_e kind);
    return (kind == CYC_FETCH) || (kind == CYC_READ);
  endfunction

endpackage

// File: rtl/mbus_tick.sv
// Phase counter (divide by N) and state counter for one bus cycle.
module mbus_tick #(
  parameter int unsigned N    = 3,
  parameter int unsigned PH_W = 2,
  parameter int unsigned ST_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [ST_W-1:0] last_st,
  output logic [PH_W-1:0] ph,
  output logic [ST_W-1:0] tst,
  output logic            state_end,
  output logic            cyc_end
);

  assign state_end = (ph == PH_W'(N - 1));
  assign cyc_end   = run && state_end && (tst == last_st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= '0;
      tst <= '0;
    end else if (start) begin
      ph  <= '0;
      tst <= '0;
    end else if (run) begin
      if (state_end) begin
        ph  <= '0;
        tst <= tst + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mbus_drive.sv
// Strobe and shared-bus decode from the current state and phase.
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int unsigned N      = 3,
  parameter int unsigned XFER_N = 3,
  parameter int unsigned PH_W   = 2,
  parameter int unsigned ST_W   = 2,
  parameter int unsigned DW     = 8
) (
  input  logic            busy,
  input  cyc_e            kind,
  input  logic [PH_W-1:0] ph,
  input  logic [ST_W-1:0] tst,
  input  logic [DW-1:0]   addr_lo,
  input  logic [DW-1:0]   wdata,
  output logic            ale,
  output logic            ad_oe,
  output logic [DW-1:0]   ad_out,
  output logic            rd_n,
  output logic            wr_n
);

  localparam int unsigned MID = N / 2;

  logic in_t1, addr_ph, thru_last, wr_win;

  assign in_t1     = (tst == '0);
  assign addr_ph   = busy && in_t1 && (ph <= PH_W'(MID));
  assign thru_last = (tst <= ST_W'(XFER_N - 1));
  assign wr_win    = (in_t1 && (ph >= PH_W'(MID))) ||
                     ((tst != '0) && (tst < ST_W'(XFER_N - 1)));

  assign ale    = busy && uses_bus(kind) && in_t1 && (ph == '0);
  assign ad_oe  = busy && uses_bus(kind) &&
                  (addr_ph || ((kind == CYC_WRITE) && thru_last));
  assign ad_out = addr_ph ? addr_lo : wdata;
  assign rd_n   = !(busy && reads_bus(kind) && thru_last);
  assign wr_n   = !(busy && (kind == CYC_WRITE) && wr_win);

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbus_pkg::*;
#(
  parameter int unsigned CLK_PER_STATE = 3,
  parameter int unsigned FETCH_STATES  = 4,
  parameter int unsigned XFER_STATES   = 3,
  parameter int unsigned AW            = 16,
  parameter int unsigned DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n
);

  localparam int unsigned PH_W = (CLK_PER_STATE > 2) ? $clog2(CLK_PER_STATE) : 1;
  localparam int unsigned ST_W = (FETCH_STATES > 2) ? $clog2(FETCH_STATES) : 1;

  logic            busy;
  cyc_e            kind_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   rdata_q;
  logic            done_q;
  logic [PH_W-1:0] ph;
  logic [ST_W-1:0] tst;
  logic            state_end, cyc_end, start, capture;
  logic [ST_W-1:0] last_st;

  assign start   = req_valid && !busy;
  assign last_st = ST_W'(cyc_states(kind_q, FETCH_STATES, XFER_STATES) - 1);
  assign capture = busy && reads_bus(kind_q) && state_end &&
                   (tst == ST_W'(XFER_STATES - 1));

  mbus_tick #(.N(CLK_PER_STATE), .PH_W(PH_W), .ST_W(ST_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy), .last_st(last_st),
    .ph(ph), .tst(tst), .state_end(state_end), .cyc_end(cyc_end)
  );

  mbus_drive #(.N(CLK_PER_STATE), .XFER_N(XFER_STATES), .PH_W(PH_W),
               .ST_W(ST_W), .DW(DW)) u_drive (
    .busy(busy), .kind(kind_q), .ph(ph), .tst(tst),
    .addr_lo(addr_q[DW-1:0]), .wdata(wdata_q),
    .ale(ale), .ad_oe(ad_oe), .ad_out(ad_out), .rd_n(rd_n), .wr_n(wr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      kind_q  <= CYC_INTRN;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= cyc_end;
      if (start) begin
        busy    <= 1'b1;
        kind_q  <= cyc_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else if (cyc_end) begin
        busy <= 1'b0;
      end
      if (capture) rdata_q <= ad_in;
    end
  end

  assign req_ready = !busy;
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign addr_hi   = addr_q[AW-1:DW];

endmodule

// File: rtl/mbus_chk.sv
module mbus_chk #(
  parameter int unsigned N    = 3,
  parameter int unsigned XFER = 3,
  parameter int unsigned PH_W = 2,
  parameter int unsigned ST_W = 2,
  parameter int unsigned HW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [PH_W-1:0] ph,
  input logic [ST_W-1:0] tst,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic [HW-1:0]   addr_hi,
  input logic            done,
  input logic            req_ready
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && rd_n && wr_n && !ad_oe));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph < PH_W'(N)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_hi));

  // R4
  ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && tst == '0 && ph == '0));

  // R8
  wr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (busy && ph == '0 && tst == ST_W'(XFER - 1)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mux_bus_seq mbus_chk #(
  .N(CLK_PER_STATE), .XFER(XFER_STATES), .PH_W(PH_W), .ST_W(ST_W), .HW(AW - DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ph(ph), .tst(tst), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .addr_hi(addr_hi), .done(done),
  .req_ready(req_ready)
);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b11;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, done, ad_oe, ale, rd_n, wr_n;
  logic [7:0] rdata, addr_hi, ad_out, ad_in, lat;

  always #5 clk = ~clk;

  mux_bus_seq #(.CLK_PER_STATE(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // external memory behind a transparent address latch
  logic [7:0] bus_mem [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(*) if (ale) lat = ad_out;
  always @(*) begin
    if (!rd_n) ad_in = bus_mem.exists(int'({addr_hi, lat})) ?
                       bus_mem[int'({addr_hi, lat})] : dflt({addr_hi, lat});
    else ad_in = 8'hEE;
  end
  always @(posedge wr_n) if (rst_n) bus_mem[int'({addr_hi, lat})] = ad_out;

  // reference model
  int k = -1;
  logic [1:0] m_kind = 2'b11;
  logic [15:0] m_addr = '0;
  logic [7:0] m_wdata = '0, e_rdata = '0;
  bit e_done = 0, seen = 0;

  function automatic int cyc_len(input logic [1:0] t);
    return (t == 2'b00) ? 4 * N : 3 * N;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      k = -1; e_done = 0;
    end else begin
      e_done = 0;
      if (k >= 0) begin
        if (k == 3 * N - 1 && m_kind <= 2'b01)
          e_rdata = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : dflt(m_addr);
        if (k == cyc_len(m_kind) - 1) begin
          if (m_kind == 2'b10) ref_mem[int'(m_addr)] = m_wdata;
          k = -1; e_done = 1;
        end else k++;
      end else if (req_valid) begin
        k = 0; m_kind = req_kind; m_addr = req_addr; m_wdata = req_wdata; seen = 1;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    bit act, e_ale, e_oe, e_rdn, e_wrn;
    act   = (k >= 0);
    e_ale = act && k == 0 && m_kind != 2'b11;
    e_oe  = act && ((m_kind <= 2'b01 && k <= 1) || (m_kind == 2'b10 && k <= 3 * N - 1));
    e_rdn = !(act && m_kind <= 2'b01 && k <= 3 * N - 1);
    e_wrn = !(act && m_kind == 2'b10 && k >= N / 2 && k <= 2 * N - 1);
    chk(req_ready == !act, "R2 ready", req_ready, !act);
    chk(ale == e_ale, act ? "R4 ale" : "R1 ale", ale, e_ale);
    chk(ad_oe == e_oe, m_kind == 2'b10 ? "R7 oe" : "R5 oe", ad_oe, e_oe);
    chk(rd_n == e_rdn, act ? "R5 rd_n" : "R1 rd_n", rd_n, e_rdn);
    chk(wr_n == e_wrn, act ? "R8 wr_n" : "R1 wr_n", wr_n, e_wrn);
    chk(done == e_done, "R10 done", done, e_done);
    if (m_kind == 2'b11 && act)
      chk(!ale && !ad_oe && rd_n && wr_n, "R9 internal", {ale, ad_oe, rd_n, wr_n}, 4'b0011);
    if (seen && rst_n) chk(addr_hi == m_addr[15:8], "R3 addr_hi", addr_hi, m_addr[15:8]);
    if (e_oe) begin
      if (k <= 1) chk(ad_out == m_addr[7:0], "R4 addr_lo", ad_out, m_addr[7:0]);
      else chk(ad_out == m_wdata, "R7 wdata", ad_out, m_wdata);
    end
    if (act && k == 2 && m_kind != 2'b11) chk(lat == m_addr[7:0], "R4 latch", lat, m_addr[7:0]);
    if (e_done && m_kind <= 2'b01) chk(rdata == e_rdata, "R6 rdata", rdata, e_rdata);
  end

  task automatic issue(input logic [1:0] t, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_kind = t; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !ale && rd_n && wr_n && !ad_oe, "R1 reset", {req_ready, ale, rd_n, wr_n, ad_oe}, 5'b10110);
    rst_n = 1;
    issue(2'b00, 16'h1234, 8'h00);
    issue(2'b01, 16'hABCD, 8'h00);
    issue(2'b10, 16'h4321, 8'h3C);
    issue(2'b01, 16'h4321, 8'h00);
    issue(2'b11, 16'h7788, 8'h99);
    issue(2'b10, 16'h00FF, 8'hA5);
    issue(2'b00, 16'h00FF, 8'h00);
    issue(2'b10, 16'hFFFF, 8'h81);
    // R10: requests while busy are ignored
    @(negedge clk);
    req_valid = 1; req_kind = 2'b01; req_addr = 16'hFFFF;
    @(negedge clk);
    req_kind = 2'b10; req_addr = 16'h0F0F; req_wdata = 8'h11;
    repeat (5) @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    // R10: back-to-back start in the done clock
    req_valid = 1; req_kind = 2'b00; req_addr = 16'h0F0F;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    req_valid = 1; req_kind = 2'b01; req_addr = 16'h2222;
    @(negedge clk);
    chk(!req_ready, "R10 no gap", req_ready, 0);
    req_valid = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule